// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block is the timekeeping core of a real-time clock. It holds hundredths of seconds, seconds, minutes, hours, day of week, day of month, month and a two-digit year as packed BCD bytes, together with a century flag that can be set to flip when the year wraps. A single-cycle enable pulse at 100 Hz advances the count, and each field carries into the next as it wraps. The length of each month, including February in leap years, is handled inside the block.

A host loads every field at once with a one-cycle write strobe. A load always clears the hundredths field, so the next full second starts from that write. A run-freeze flag sits in the seconds byte. While that flag is set, ticks are ignored. The whole time image appears on one 64-bit output, which a register front end can read.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the output reads year 00, month 01, date 01, day of week 1, hour byte 00 (century flags clear), minutes 00, seconds byte 00 (not frozen) and hundredths 00.
- R2: Each tick advances hundredths through 00..99 in BCD, one step per tick. When it wraps from 99 to 00, seconds advance by one in the same cycle. Seconds change at no other time, except on a load.
- R3: Seconds and minutes count 00..59, and hours count 00..23, all in BCD. Each wraps to 00 and carries into the next field when it passes its top value.
- R4: Day of week sits in the low three bits of its byte (upper bits read 0), counts 1..7, and goes from 7 back to 1 at midnight.
- R5: Date counts from 01 to the length of the current month, then returns to 01 and advances the month. April, June, September and November have 30 days and February has 28. February has 29 days when the BCD year is divisible by 4 (00 counts as a leap year). All other months have 31 days.
- R6: Month counts 01..12 and returns to 01 with a carry into the year. The year counts 00..99 and wraps to 00.
- R7: Bit 7 of the hour byte is the century enable and bit 6 is the century flag. The flag inverts when the year wraps from 99 to 00 only if the enable is 1. Otherwise it keeps its value.
- R8: Bit 7 of the seconds byte is the freeze flag. While it is 1 and no load occurs, ticks change nothing on the output. Counting resumes once a load clears it.
- R9: When wr_en is high at a clock edge, every field takes its input value on that edge, and a tick in the same cycle is ignored. Hundredths becomes 00 whatever it held before. Bits outside each field read 0: minutes keep 7 bits, hours 6 bits plus the two century bits, date 6 bits, month 5 bits and day of week 3 bits.
- R10: time_vec packs the fields from least significant byte upward: hundredths [7:0], seconds byte [15:8], minutes [23:16], hour byte [31:24], day of week [39:32], date [47:40], month [55:48], year [63:56].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 100 Hz advance pulse |
| wr_en | input | 1 | Load strobe for all fields |
| wr_sec | input | 8 | Seconds BCD in [6:0], freeze flag in [7] |
| wr_min | input | 8 | Minutes BCD |
| wr_hour | input | 8 | Century enable [7], century flag [6], hours BCD [5:0] |
| wr_dow | input | 8 | Day of week in [2:0] |
| wr_date | input | 8 | Day of month BCD |
| wr_month | input | 8 | Month BCD |
| wr_year | input | 8 | Year BCD |
| time_vec | output | 64 | Packed time image, layout per R10 |

## Verification
Every counter register is visible on time_vec, so a wrong internal value shows up in the first cycle after the edge that stored it. A bad carry or month-length decision, however, only appears on the tick that reaches the boundary. The bench therefore loads each field just below its boundary and drives one hundred ticks, which puts every rollover path into a single observed cycle. These include the end of February in leap and common years, the 30- and 31-day months, and the wrap from 23:59:59.99 on 31 December of year 99, with the century enable both set and cleared. A freeze flag that leaks ticks, or a load that leaves hundredths nonzero, shows on the output on the next sampled cycle.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [7:0]  wr_sec,
  input  logic [7:0]  wr_min,
  input  logic [7:0]  wr_hour,
  input  logic [7:0]  wr_dow,
  input  logic [7:0]  wr_date,
  input  logic [7:0]  wr_month,
  input  logic [7:0]  wr_year,
  output logic [63:0] time_vec
);

  logic [7:0] hund, year;
  logic [6:0] sec, min;
  logic [5:0] hour, date;
  logic [4:0] month;
  logic [2:0] dow;
  logic       stop, cen, cflag;

  function automatic logic [7:0] binc(input logic [7:0] v);
    binc = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [7:0] hund_n, sec_n, min_n, hour_n, date_n, month_n, year_n;
  assign hund_n  = binc(hund);
  assign sec_n   = binc({1'b0, sec});
  assign min_n   = binc({1'b0, min});
  assign hour_n  = binc({2'b00, hour});
  assign date_n  = binc({2'b00, date});
  assign month_n = binc({3'b000, month});
  assign year_n  = binc(year);

  logic leap;
  assign leap = year[4] ? (year[3:0] == 4'd2 || year[3:0] == 4'd6)
                        : (year[3:0] == 4'd0 || year[3:0] == 4'd4 || year[3:0] == 4'd8);

  logic [5:0] mlen;
  always_comb begin
    case (month)
      5'h02:                         mlen = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11:    mlen = 6'h30;
      default:                       mlen = 6'h31;
    endcase
  end

  logic run, c_s, c_m, c_hr, c_d, c_mo, c_y;
  assign run  = tick & ~stop & ~wr_en;
  assign c_s  = run  & (hund  == 8'h99);
  assign c_m  = c_s  & (sec   == 7'h59);
  assign c_hr = c_m  & (min   == 7'h59);
  assign c_d  = c_hr & (hour  == 6'h23);
  assign c_mo = c_d  & (date  == mlen);
  assign c_y  = c_mo & (month == 5'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hund  <= 8'h00;
      sec   <= 7'h00;
      stop  <= 1'b0;
      min   <= 7'h00;
      hour  <= 6'h00;
      cen   <= 1'b0;
      cflag <= 1'b0;
      dow   <= 3'd1;
      date  <= 6'h01;
      month <= 5'h01;
      year  <= 8'h00;
    end else if (wr_en) begin
      hund  <= 8'h00;
      sec   <= wr_sec[6:0];
      stop  <= wr_sec[7];
      min   <= wr_min[6:0];
      hour  <= wr_hour[5:0];
      cen   <= wr_hour[7];
      cflag <= wr_hour[6];
      dow   <= wr_dow[2:0];
      date  <= wr_date[5:0];
      month <= wr_month[4:0];
      year  <= wr_year;
    end else begin
      if (run)  hund  <= (hund == 8'h99) ? 8'h00 : hund_n;
      if (c_s)  sec   <= (sec == 7'h59) ? 7'h00 : sec_n[6:0];
      if (c_m)  min   <= (min == 7'h59) ? 7'h00 : min_n[6:0];
      if (c_hr) hour  <= (hour == 6'h23) ? 6'h00 : hour_n[5:0];
      if (c_d)  dow   <= (dow == 3'd7) ? 3'd1 : dow + 3'd1;
      if (c_d)  date  <= (date == mlen) ? 6'h01 : date_n[5:0];
      if (c_mo) month <= (month == 5'h12) ? 5'h01 : month_n[4:0];
      if (c_y)  year  <= (year == 8'h99) ? 8'h00 : year_n;
      if (c_y && cen) cflag <= ~cflag;
    end
  end

  assign time_vec = {year, 3'b000, month, 2'b00, date, 5'b00000, dow,
                     cen, cflag, hour, 1'b0, min, stop, sec, hund};

  // R8: frozen counter ignores ticks
  a_r8_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_en) |=> $stable(time_vec));

  // R9: a load leaves hundredths at 00
  a_r9_load_clears_hund: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (time_vec[7:0] == 8'h00));

  // R2: seconds move only when hundredths wraps
  a_r2_sec_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(tick && !stop && hund == 8'h99)) |=> $stable(time_vec[14:8]));

  // R7: century flag holds while the enable is clear
  a_r7_century_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cen) |=> $stable(cflag));

  // R4: day of week never counts into zero
  a_r4_dow_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && dow != 3'd0) |=> (time_vec[39:32] != 8'h00));

  // R6: month never counts into zero
  a_r6_month_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && month != 5'h00) |=> (time_vec[55:48] != 8'h00));

endmodule

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_sec = 8'h00, wr_min = 8'h00, wr_hour = 8'h00, wr_dow = 8'h00;
  logic [7:0] wr_date = 8'h00, wr_month = 8'h00, wr_year = 8'h00;
  logic [63:0] time_vec;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  bcd_rtc_core dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_sec(wr_sec), .wr_min(wr_min), .wr_hour(wr_hour), .wr_dow(wr_dow),
    .wr_date(wr_date), .wr_month(wr_month), .wr_year(wr_year),
    .time_vec(time_vec)
  );

  // load bytes {sec,min,hour,dow,date,month,year}, then 100 ticks, expected image
  localparam int NV = 14;
  localparam logic [119:0] VEC [NV] = '{
    {56'h59_59_A3_07_31_12_99, 64'h00_01_01_01_C0_00_00_00},
    {56'h59_59_E3_07_31_12_99, 64'h00_01_01_01_80_00_00_00},
    {56'h59_59_63_07_31_12_99, 64'h00_01_01_01_40_00_00_00},
    {56'h59_59_23_03_28_02_24, 64'h24_02_29_04_00_00_00_00},
    {56'h59_59_23_03_28_02_23, 64'h23_03_01_04_00_00_00_00},
    {56'h59_59_23_02_29_02_00, 64'h00_03_01_03_00_00_00_00},
    {56'h59_59_23_05_30_04_05, 64'h05_05_01_06_00_00_00_00},
    {56'h59_59_23_01_30_01_11, 64'h11_01_31_02_00_00_00_00},
    {56'h59_59_23_04_30_11_11, 64'h11_12_01_05_00_00_00_00},
    {56'h59_59_23_01_31_01_20, 64'h20_02_01_02_00_00_00_00},
    {56'h59_34_12_02_15_06_10, 64'h10_06_15_02_12_35_00_00},
    {56'h59_59_09_02_15_06_10, 64'h10_06_15_02_10_00_00_00},
    {56'h59_59_23_07_15_06_10, 64'h10_06_16_01_00_00_00_00},
    {56'h09_00_00_01_01_01_00, 64'h00_01_01_01_00_00_10_00}
  };

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic load(input logic [55:0] b, input logic with_tick);
    @(negedge clk);
    {wr_sec, wr_min, wr_hour, wr_dow, wr_date, wr_month, wr_year} = b;
    wr_en = 1'b1;
    tick = with_tick;
    @(negedge clk);
    wr_en = 1'b0;
    tick = 1'b0;
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(time_vec, 64'h00_01_01_01_00_00_00_00, "R1 reset state");

    do_ticks(9);
    check(time_vec, 64'h00_01_01_01_00_00_00_09, "R2 hundredths 09");
    do_ticks(1);
    check(time_vec, 64'h00_01_01_01_00_00_00_10, "R2 hundredths BCD carry");
    do_ticks(89);
    check(time_vec, 64'h00_01_01_01_00_00_00_99, "R2 hundredths 99");
    do_ticks(1);
    check(time_vec, 64'h00_01_01_01_00_00_01_00, "R2 wrap into seconds");

    for (int k = 0; k < NV; k++) begin
      load(VEC[k][119:64], 1'b0);
      do_ticks(100);
      check(time_vec, VEC[k][63:0], "R3 R4 R5 R6 R7 carry table");
    end

    load(56'hB0_10_05_02_03_04_05, 1'b0);
    do_ticks(5);
    check(time_vec, 64'h05_04_03_02_05_10_B0_00, "R8 frozen ignores ticks");
    load(56'h30_10_05_02_03_04_05, 1'b0);
    do_ticks(3);
    check(time_vec, 64'h05_04_03_02_05_10_30_03, "R8 resumes after clear");

    do_ticks(4);
    load(56'h20_15_11_03_12_07_44, 1'b1);
    check(time_vec, 64'h44_07_12_03_11_15_20_00, "R9 load clears hundredths, tick ignored");

    load(56'h45_D9_E3_FE_F1_F2_77, 1'b0);
    check(time_vec, 64'h77_12_31_06_E3_59_45_00, "R9 R10 field masks and layout");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule